// File: doc/BRIEF.md
# Halfword-Parcel Instruction Fetch Unit

This unit fetches one instruction at a time for a core whose instruction memory port is 16 bits wide. A start strobe hands it a program counter and the current state of the compressed-instruction enable. The unit first checks that the program counter is aligned. A misaligned address raises a fetch-misaligned trap before any memory traffic takes place. An aligned address is read one 16-bit parcel at a time.

With compressed instructions enabled, the low two bits of the first parcel decide the instruction width. If they are not 2'b11, the instruction is 16 bits wide and the unit finishes after a single read. It never touches the halfword that follows. This keeps a short instruction at the top of the address space from causing a stray access past the end of memory. With compressed instructions disabled, every instruction is 32 bits wide and both parcels are always read.

When it finishes, the unit reports the assembled instruction, its size in bytes and the fall-through address (PC plus size). The core uses that address as the next sequential PC and as the link value for jump-and-link.

Top module: `pfetch_unit`

## Requirements
- R1: After reset, mem_req, done and trap are all low, and they stay low until a start is accepted.
- R2: An accepted start with an aligned PC makes the first request at mem_addr equal to that PC. mem_req and mem_addr hold steady on every cycle in which mem_ready is low.
- R3: With c_en high, a first parcel whose bits [1:0] are not 2'b11 ends the fetch after one access. The result is size 2 and instr = {16'h0000, parcel}.
- R4: A first parcel whose bits [1:0] are 2'b11 causes a second access at PC+2. The result is size 4, with the PC parcel in instr[15:0] and the PC+2 parcel in instr[31:16].
- R5: With c_en low, both parcels are always read and size is 4, whatever the low bits of the first parcel.
- R6: The start is misaligned if c_en is high and pc bit 0 is set, or if c_en is low and pc bits [1:0] are not 00. A misaligned start raises trap for exactly one cycle, one cycle after the start. In that cycle trap_cause is 0 and trap_val is the PC. No memory request is made and done stays low.
- R7: done is a one-cycle pulse. While done is high, next_pc equals PC plus size, modulo 2^ADDR_W. size is encoded as 3'd2 or 3'd4.
- R8: A start raised while the unit is busy (fetching, done or trap cycle) is ignored. It changes neither the result of the current fetch nor the memory traffic that follows.
- R9: A compressed instruction at the last halfword of the address space completes without any access to the wrapped address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fetch at pc (accepted only when idle) |
| pc | input | ADDR_W | Byte address of the instruction |
| c_en | input | 1 | Compressed instructions enabled |
| mem_req | output | 1 | Parcel read request |
| mem_addr | output | ADDR_W | Byte address of the requested parcel |
| mem_rdata | input | 16 | Parcel data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current request |
| done | output | 1 | Instruction result valid (one cycle) |
| instr | output | 32 | Assembled instruction |
| size | output | 3 | Instruction size in bytes (2 or 4) |
| next_pc | output | ADDR_W | Fall-through address PC+size |
| trap | output | 1 | Fetch-misaligned trap (one cycle) |
| trap_cause | output | 4 | Trap cause code (0) |
| trap_val | output | ADDR_W | Faulting PC |

## Verification
The bench builds the unit with ADDR_W = 16. This makes the top of the byte space (0xFFFC and 0xFFFE) reachable as directed cases, so the wrap to address 0 after a short instruction at 0xFFFE can be watched directly. Parcel contents come from an address hash whose low two bits vary. Random PCs in both enable states therefore cover narrow, wide and misaligned fetches. Random memory wait states test the hold-while-not-ready rule. Starts injected during busy cycles test that such starts are ignored.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic [2:0] {
    PF_IDLE     = 3'd0,
    PF_FETCH_LO = 3'd1,
    PF_FETCH_HI = 3'd2,
    PF_DONE     = 3'd3,
    PF_TRAP     = 3'd4
  } pf_state_e;

  localparam int unsigned PARCEL_W = 16;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned SIZE_W   = 3;
  localparam int unsigned CAUSE_W  = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_MISALIGNED = '0;

  // A parcel opens a 32-bit instruction when its two low bits are both set.
  function automatic logic parcel_is_wide(input logic [PARCEL_W-1:0] p);
    return p[1:0] == 2'b11;
  endfunction

  // Alignment rule depends on whether 16-bit instructions are allowed.
  function automatic logic fetch_misaligned(input logic [1:0] low, input logic c_on);
    return c_on ? low[0] : (low != 2'b00);
  endfunction

  function automatic logic [SIZE_W-1:0] size_bytes(input logic wide);
    return wide ? SIZE_W'(4) : SIZE_W'(2);
  endfunction

endpackage

// File: rtl/pf_align_gate.sv
module pf_align_gate #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              c_en,
  output logic              misaligned
);
  import pf_pkg::*;

  always_comb misaligned = fetch_misaligned(pc[1:0], c_en);

endmodule

// File: rtl/pf_fetch_fsm.sv
module pf_fetch_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              misaligned,
  input  logic              mem_ready,
  input  logic              lo_wide,
  output pf_pkg::pf_state_e state,
  output logic              start_acc,
  output logic              cap_lo,
  output logic              cap_hi
);
  import pf_pkg::*;

  pf_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PF_IDLE:     if (start) nxt = misaligned ? PF_TRAP : PF_FETCH_LO;
      PF_FETCH_LO: if (mem_ready) nxt = lo_wide ? PF_FETCH_HI : PF_DONE;
      PF_FETCH_HI: if (mem_ready) nxt = PF_DONE;
      PF_DONE:     nxt = PF_IDLE;
      PF_TRAP:     nxt = PF_IDLE;
      default:     nxt = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PF_IDLE;
    else        state <= nxt;
  end

  assign start_acc = start && (state == PF_IDLE);
  assign cap_lo    = (state == PF_FETCH_LO) && mem_ready;
  assign cap_hi    = (state == PF_FETCH_HI) && mem_ready;

endmodule

// File: rtl/pf_parcel_store.sv
module pf_parcel_store #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cap_lo,
  input  logic                           cap_hi,
  input  logic                           force_wide,
  input  logic [pf_pkg::PARCEL_W-1:0]    rdata,
  input  logic [ADDR_W-1:0]              pc_base,
  output logic                           lo_wide,
  output logic [pf_pkg::INSTR_W-1:0]     instr,
  output logic [pf_pkg::SIZE_W-1:0]      size,
  output logic [ADDR_W-1:0]              next_pc
);
  import pf_pkg::*;

  localparam int unsigned SLOTS = INSTR_W / PARCEL_W;

  logic [SLOTS-1:0]    cap;
  logic [PARCEL_W-1:0] slot_q [SLOTS];
  logic                wide_q;

  assign cap     = {cap_hi, cap_lo};
  assign lo_wide = force_wide || parcel_is_wide(rdata);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot_q[g] <= '0;
      else if (cap[g]) slot_q[g] <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wide_q <= 1'b0;
    else if (cap_lo) wide_q <= lo_wide;
  end

  always_comb begin
    instr   = wide_q ? {slot_q[1], slot_q[0]} : {{PARCEL_W{1'b0}}, slot_q[0]};
    size    = size_bytes(wide_q);
    next_pc = pc_base + ADDR_W'(size);
  end

endmodule

// File: rtl/pfetch_unit.sv
module pfetch_unit #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [ADDR_W-1:0] pc,
  input  logic          c_en,
  output logic          mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          done,
  output logic [31:0]   instr,
  output logic [2:0]    size,
  output logic [ADDR_W-1:0] next_pc,
  output logic          trap,
  output logic [3:0]    trap_cause,
  output logic [ADDR_W-1:0] trap_val
);
  import pf_pkg::*;

  localparam logic [ADDR_W-1:0] PARCEL_STEP = ADDR_W'(PARCEL_W / 8);

  pf_state_e         state;
  logic              start_acc;
  logic              start_mis;
  logic              cap_lo;
  logic              cap_hi;
  logic              lo_wide;
  logic [ADDR_W-1:0] pc_q;
  logic              c_q;

  pf_align_gate #(.ADDR_W(ADDR_W)) u_align (
    .pc         (pc),
    .c_en       (c_en),
    .misaligned (start_mis)
  );

  pf_fetch_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .misaligned (start_mis),
    .mem_ready  (mem_ready),
    .lo_wide    (lo_wide),
    .state      (state),
    .start_acc  (start_acc),
    .cap_lo     (cap_lo),
    .cap_hi     (cap_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      c_q  <= 1'b0;
    end else if (start_acc) begin
      pc_q <= pc;
      c_q  <= c_en;
    end
  end

  pf_parcel_store #(.ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_lo     (cap_lo),
    .cap_hi     (cap_hi),
    .force_wide (!c_q),
    .rdata      (mem_rdata),
    .pc_base    (pc_q),
    .lo_wide    (lo_wide),
    .instr      (instr),
    .size       (size),
    .next_pc    (next_pc)
  );

  assign mem_req    = (state == PF_FETCH_LO) || (state == PF_FETCH_HI);
  assign mem_addr   = (state == PF_FETCH_HI) ? pc_q + PARCEL_STEP : pc_q;
  assign done       = (state == PF_DONE);
  assign trap       = (state == PF_TRAP);
  assign trap_cause = CAUSE_FETCH_MISALIGNED;
  assign trap_val   = pc_q;

endmodule

// File: rtl/pf_fetch_chk.sv
module pf_fetch_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_acc,
  input logic              start_mis,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              trap,
  input logic [3:0]        trap_cause,
  input logic [31:0]       instr,
  input logic [2:0]        size
);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  // R6
  trap_before_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && start_mis |=> trap && !mem_req);

  // R6
  trap_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !done && !mem_req && trap_cause == 4'd0);

  // R3
  narrow_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && size == 3'd2 |-> instr[1:0] != 2'b11 && instr[31:16] == 16'h0);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> size == 3'd2 || size == 3'd4);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done || trap) |-> !start_acc);

endmodule

bind pfetch_unit pf_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_acc  (start_acc),
  .start_mis  (start_mis),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .done       (done),
  .trap       (trap),
  .trap_cause (trap_cause),
  .instr      (instr),
  .size       (size)
);

// File: tb/tb_pfetch_unit.sv
`timescale 1ns/1ps
module tb_pfetch_unit;

  localparam int unsigned AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          c_en = 1'b0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_rdata = '0;
  logic          mem_ready = 1'b0;
  logic          done;
  logic [31:0]   instr;
  logic [2:0]    size;
  logic [AW-1:0] next_pc;
  logic          trap;
  logic [3:0]    trap_cause;
  logic [AW-1:0] trap_val;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int wait_left = 0;
  logic [AW-1:0] acc_log [8];
  int acc_n = 0;

  always #4 clk = ~clk;

  pfetch_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .c_en(c_en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done(done), .instr(instr), .size(size),
    .next_pc(next_pc), .trap(trap), .trap_cause(trap_cause), .trap_val(trap_val)
  );

  // Parcel content as a function of address; two top addresses pinned.
  function automatic logic [15:0] parcel_at(input logic [AW-1:0] a);
    logic [15:0] h;
    h = (a * 16'h9E37) ^ (a >> 3) ^ 16'h5A5A;
    if (a == 16'hFFFE) h[1:0] = 2'b10;
    if (a == 16'hFFFC) h[1:0] = 2'b11;
    return h;
  endfunction

  function automatic bit bad_align(input logic [AW-1:0] p, input logic c);
    if (c) return p[0] == 1'b1;
    return p[1:0] != 2'b00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: random wait states, one access logged per handshake.
  always @(negedge clk) begin
    mem_ready <= 1'b0;
    if (rst_n && mem_req) begin
      if (wait_left == 0) begin
        mem_ready <= 1'b1;
        mem_rdata <= parcel_at(mem_addr);
        if (acc_n < 8) acc_log[acc_n] = mem_addr;
        acc_n++;
        wait_left = $urandom % 3;
      end else begin
        wait_left--;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic run_op(input logic [AW-1:0] p, input logic c, input bit spur);
    logic [15:0] lo, hi;
    bit          mis, wide;
    logic [31:0] e_instr;
    logic [2:0]  e_size;
    int          t;
    bit          got_done, got_trap;
    mis  = bad_align(p, c);
    lo   = parcel_at(p);
    hi   = parcel_at(p + 16'd2);
    wide = !c || (lo[1:0] == 2'b11);
    e_instr = wide ? {hi, lo} : {16'h0, lo};
    e_size  = wide ? 3'd4 : 3'd2;
    @(negedge clk);
    acc_n = 0;
    pc = p; c_en = c; start = 1'b1;
    got_done = 0; got_trap = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0) begin
        start = spur;
        pc = p ^ 16'h0104;
        c_en = ~c;
      end else begin
        start = 1'b0;
      end
      if (k == 0 && mis) begin
        // R6: trap one cycle after the start
        chk(trap === 1'b1, "R6 trap raised", {31'h0, trap}, 32'h1);
      end
      if (done || trap) begin
        got_done = done; got_trap = trap;
        t = k;
        break;
      end
    end
    if (mis) begin
      chk(got_trap && !got_done, "R6 trap not done", {30'h0, got_trap, got_done}, 32'h2);
      chk(trap_val === p, "R6 trap_val", {16'h0, trap_val}, {16'h0, p});
      chk(trap_cause === 4'd0, "R6 cause", {28'h0, trap_cause}, 32'h0);
      chk(acc_n == 0, "R6 no access", acc_n, 0);
    end else begin
      chk(got_done && !got_trap, "R7 done seen", {30'h0, got_trap, got_done}, 32'h1);
      chk(instr === e_instr, wide ? (c ? "R4 instr" : "R5 instr") : "R3 instr", instr, e_instr);
      chk(size === e_size, wide ? (c ? "R4 size" : "R5 size") : "R3 size", {29'h0, size}, {29'h0, e_size});
      chk(next_pc === p + AW'(e_size), "R7 next_pc", {16'h0, next_pc}, {16'h0, p + AW'(e_size)});
      chk(acc_n == (wide ? 2 : 1), "R4 access count", acc_n, wide ? 2 : 1);
      if (acc_n >= 1) chk(acc_log[0] === p, "R2 first address", {16'h0, acc_log[0]}, {16'h0, p});
      if (wide && acc_n >= 2)
        chk(acc_log[1] === p + 16'd2, "R4 second address", {16'h0, acc_log[1]}, {16'h0, p + 16'd2});
    end
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    // R8: a start seen during the busy cycles left no further activity
    chk(!mem_req && !done && !trap, "R8 busy start ignored", {29'h0, mem_req, done, trap}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mem_req && !done && !trap, "R1 reset outputs", {29'h0, mem_req, done, trap}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mem_req && !done && !trap, "R1 idle after reset", {29'h0, mem_req, done, trap}, 32'h0);

    // R9: compressed at the top halfword, no wrap access
    run_op(16'hFFFE, 1'b1, 1'b0);
    chk(acc_n == 1 && acc_log[0] === 16'hFFFE, "R9 no wrapped access", acc_n, 1);
    run_op(16'hFFFC, 1'b1, 1'b0);   // R4 wide at top word
    run_op(16'hFFFC, 1'b0, 1'b1);   // R5 with busy start
    run_op(16'hFFFE, 1'b0, 1'b0);   // R6 half-aligned, C off
    run_op(16'h0001, 1'b1, 1'b1);   // R6 odd, C on, busy start
    run_op(16'h0003, 1'b0, 1'b0);   // R6 odd, C off
    run_op(16'h0002, 1'b1, 1'b0);   // R2 half-aligned, C on

    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] p;
      logic c;
      int sel;
      p   = AW'($urandom);
      c   = 1'($urandom);
      sel = $urandom % 10;
      if (sel < 8) p = c ? {p[AW-1:1], 1'b0} : {p[AW-1:2], 2'b00};
      run_op(p, c, ($urandom % 4) == 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule